// File: doc/BRIEF.md
# Oversampling Serial Receiver with Centre-Sample Voting

This block recovers asynchronous serial frames from a single receive line. An external baud generator supplies a sample-enable pulse, `tick`. Each bit period lasts sixteen of these pulses in normal mode and eight in double-speed mode. The `dbl` input selects the mode and may change while the receiver is idle. The line first passes through a two-flop synchronizer. A falling edge, seen between two consecutive sample pulses, starts a frame. After that, the level of every bit is a two-out-of-three majority vote over the centre samples of that bit.

A frame consists of a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. The parity bit is enabled by `par_en`, and `par_odd` selects odd or even parity. Further stop bits are not examined. When the stop bit has been voted, the receiver presents the data byte, a parity-error flag and a frame-error flag, and raises `valid` for one clock cycle. It then re-arms for the next start edge. In normal mode it re-arms at once. In double-speed mode it re-arms one sample later.

Top module: `uart_vote_rx`

## Requirements
- R1: In normal mode (`dbl`=0) a bit lasts 16 sample pulses, where sample 1 is the pulse that first sees the line low. The bit level is voted from samples 8, 9 and 10. Clock cycles without `tick` do not advance the sampling.
- R2: In double-speed mode (`dbl`=1) a bit lasts 8 sample pulses and is voted from samples 4, 5 and 6.
- R3: A data bit takes the majority of its three voting samples: one disagreeing voting sample leaves the bit unchanged, and two disagreeing voting samples invert it.
- R4: The start bit is confirmed by the same vote. If the vote is high, the receiver treats the edge as noise, returns to idle and produces no frame. If a single voting sample is high, the start bit is still accepted.
- R5: The eight data bits arrive least significant bit first and appear on `data_out` with bit 0 taken from the first data bit.
- R6: With `par_en`=1 a parity bit follows the data. It is expected to equal the XOR of the data bits when `par_odd`=0, and the inverse of that XOR when `par_odd`=1. `par_err` is 1 when the voted parity bit differs from this value. With `par_en`=0 no parity bit is sampled and `par_err` is 0.
- R7: `frm_err` is 1 exactly when the voted first stop bit is 0.
- R8: `valid` is high for one clock cycle, in the cycle that follows the sample pulse carrying the third stop-bit voting sample. In that cycle `data_out`, `par_err` and `frm_err` hold the values of this frame, and they keep them until the next `valid`.
- R9: In normal mode, a line low at stop-bit sample 11, with sample 10 high, is accepted as the start of the next frame.
- R10: In double-speed mode, stop-bit sample 7 is ignored. A low at sample 7 does not start a frame. A high-to-low change between samples 7 and 8 does start one.
- R11: After reset, `valid`, `par_err` and `frm_err` are 0, `data_out` is zero, and the receiver is idle with the line taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sample-enable pulse from the baud generator |
| dbl | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Asynchronous serial receive line |
| data_out | output | DATA_W | Last received data word |
| par_err | output | 1 | Parity mismatch in the last frame |
| frm_err | output | 1 | Stop bit of the last frame voted low |
| valid | output | 1 | One-cycle strobe that marks a completed frame |

## Verification
The hardest case to reach from the ports is the re-arm point in double-speed mode. A frame whose start bit begins on stop-bit sample 7 must be ignored. A frame that starts one sample later must be received. The bench drives the line at the level of individual sample pulses. It ends a frame with a stop bit that is exactly six or exactly seven samples long and then sends the next start bit at once. The frame that begins early carries all-zero data, so the line never rises until its stop bit and no later edge can resynchronise the receiver. A receiver that re-arms one sample too early then shows an extra frame on `valid`. The same sample-level driver also flips chosen voting samples, to exercise noisy start bits and majority decisions.

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbl,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rxd,
  output logic [DATA_W-1:0] data_out,
  output logic              par_err,
  output logic              frm_err,
  output logic              valid
);
  localparam int CW = $clog2(OVS + 1);
  localparam int BW = $clog2(DATA_W + 3);

  typedef enum logic [1:0] {IDLE, BITS, HOLD} st_t;

  st_t              st;
  logic             s1, rx_s, rx_prev;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    idx;
  logic [DATA_W-1:0] shreg;
  logic             v0, v1, pbit;

  wire [CW-1:0] nsmp     = dbl ? CW'(OVS / 2) : CW'(OVS);
  wire [CW-1:0] vote_a   = nsmp >> 1;
  wire [CW-1:0] vote_b   = vote_a + CW'(1);
  wire [CW-1:0] vote_c   = vote_a + CW'(2);
  wire [CW-1:0] smp      = (cnt == nsmp) ? CW'(1) : cnt + CW'(1);
  wire          maj      = (v0 & v1) | (v0 & rx_s) | (v1 & rx_s);
  wire [BW-1:0] stop_idx = par_en ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
  wire          pexp     = ^shreg ^ par_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      s1       <= 1'b1;
      rx_s     <= 1'b1;
      rx_prev  <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      v0       <= 1'b1;
      v1       <= 1'b1;
      pbit     <= 1'b0;
      data_out <= '0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      valid    <= 1'b0;
    end else begin
      valid <= 1'b0;
      s1    <= rxd;
      rx_s  <= s1;
      if (tick) begin
        rx_prev <= rx_s;
        case (st)
          IDLE: if (rx_prev && !rx_s) begin
            st  <= BITS;
            cnt <= CW'(1);
            idx <= '0;
          end
          HOLD: st <= IDLE;
          default: begin
            cnt <= smp;
            if (smp == vote_a) v0 <= rx_s;
            if (smp == vote_b) v1 <= rx_s;
            if (smp == vote_c) begin
              idx <= idx + BW'(1);
              if (idx == '0) begin
                if (maj) st <= IDLE;
              end else if (idx <= BW'(DATA_W)) begin
                shreg <= {maj, shreg[DATA_W-1:1]};
              end else if (idx != stop_idx) begin
                pbit <= maj;
              end
              if (idx == stop_idx) begin
                valid    <= 1'b1;
                data_out <= shreg;
                frm_err  <= !maj;
                par_err  <= par_en && (pbit != pexp);
                st       <= dbl ? HOLD : IDLE;
              end
            end
          end
        endcase
      end
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BITS) |-> (cnt != '0 && cnt <= nsmp));

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_valid_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(tick));

  assert_hold_dbl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |-> dbl);

endmodule

// File: tb/uart_vote_rx_tb_top.sv
`timescale 1ns/1ps
module uart_vote_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick;
  logic dbl = 1'b0;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic rxd = 1'b1;
  logic [7:0] data_out;
  logic par_err, frm_err, valid;
  logic [1:0] div = 2'd0;

  int errors = 0;
  int checks = 0;
  int unexp = 0;
  int cycles = 0;

  typedef struct {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign tick = (div == 2'd3);

  uart_vote_rx dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbl(dbl), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .data_out(data_out), .par_err(par_err),
    .frm_err(frm_err), .valid(valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (q.size() == 0) begin
        unexp++;
        errors++;
        checks++;
        $display("FAIL R4/R10 unexpected frame actual=%0h expected=none", data_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({data_out, par_err, frm_err} == {e.d, e.pe, e.fe}, e.tag,
              {data_out, par_err, frm_err}, {e.d, e.pe, e.fe});
      end
    end
  end

  task automatic drive_sample(input logic v);
    rxd = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v, input int n, input int f1, input int f2);
    for (int s = 1; s <= n; s++)
      drive_sample((s == f1 || s == f2) ? ~v : v);
  endtask

  task automatic idle(input int n);
    drive_bit(1'b1, n, 0, 0);
  endtask

  task automatic send(input logic [7:0] d, input bit pe, input bit po, input bit badp,
                      input logic sv, input int stop_len, input int fbit,
                      input int f1, input int f2, input bit expf,
                      input logic [7:0] xd, input string tag);
    int n;
    exp_t e;
    n = dbl ? 8 : 16;
    par_en = pe;
    par_odd = po;
    if (expf) begin
      e.d = xd; e.pe = pe & badp; e.fe = ~sv; e.tag = tag;
      q.push_back(e);
    end
    drive_bit(1'b0, n, fbit == 0 ? f1 : 0, fbit == 0 ? f2 : 0);
    for (int i = 0; i < 8; i++)
      drive_bit(d[i], n, fbit == i + 1 ? f1 : 0, fbit == i + 1 ? f2 : 0);
    if (pe) drive_bit(^d ^ po ^ badp, n, 0, 0);
    drive_bit(sv, stop_len, 0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    int u0;
    repeat (5) @(negedge clk);
    // R11 reset state
    check(valid == 1'b0 && par_err == 1'b0 && frm_err == 1'b0 && data_out == 8'h00,
          "R11 reset outputs", {data_out, valid, par_err, frm_err}, 0);
    rst_n = 1'b1;
    do @(negedge clk); while (div != 2'd0);
    idle(4);

    // R1 R5 plain frame, normal mode
    send(8'hA5, 0, 0, 0, 1, 16, -1, 0, 0, 1, 8'hA5, "R1 R5 data normal");
    idle(3);
    // R6 parity variants
    send(8'h3C, 1, 0, 0, 1, 16, -1, 0, 0, 1, 8'h3C, "R6 even parity ok");
    send(8'h3D, 1, 1, 0, 1, 16, -1, 0, 0, 1, 8'h3D, "R6 odd parity ok");
    send(8'h81, 1, 0, 1, 1, 16, -1, 0, 0, 1, 8'h81, "R6 parity error");
    idle(2);
    // R7 frame error
    send(8'h96, 0, 0, 0, 0, 16, -1, 0, 0, 1, 8'h96, "R7 stop low");
    idle(6);

    // R8 strobe timing: valid right after the tick carrying stop sample 10
    send(8'h42, 0, 0, 0, 1, 10, -1, 0, 0, 1, 8'h42, "R8 data");
    check(valid == 1'b1, "R8 valid after stop vote", valid, 1);
    @(negedge clk);
    check(valid == 1'b0, "R8 valid one cycle", valid, 0);
    repeat (3) @(negedge clk);
    idle(5);
    check(data_out == 8'h42, "R8 data held", data_out, 8'h42);

    // R3 majority on data bits
    send(8'h00, 0, 0, 0, 1, 16, 1, 9, 0, 1, 8'h00, "R3 one flip ignored");
    send(8'h00, 0, 0, 0, 1, 16, 2, 8, 10, 1, 8'h02, "R3 two flips invert");
    // R4 start bit with one high voting sample still accepted
    send(8'h77, 0, 0, 0, 1, 16, 0, 9, 0, 1, 8'h77, "R4 start one flip");
    idle(2);
    // R4 noise on the line rejected
    u0 = unexp;
    drive_bit(1'b0, 3, 0, 0);
    idle(20);
    drive_bit(1'b0, 7, 0, 0);
    idle(20);
    check(unexp == u0, "R4 glitch rejected", unexp - u0, 0);
    send(8'h5A, 0, 0, 0, 1, 16, -1, 0, 0, 1, 8'h5A, "R4 recovery");
    idle(2);

    // R9 back-to-back with start at stop sample 11
    send(8'h11, 0, 0, 0, 1, 10, -1, 0, 0, 1, 8'h11, "R9 first");
    send(8'h22, 0, 0, 0, 1, 16, -1, 0, 0, 1, 8'h22, "R9 early start");
    idle(4);

    // R2 double-speed mode
    dbl = 1'b1;
    idle(4);
    send(8'hC3, 1, 1, 0, 1, 8, -1, 0, 0, 1, 8'hC3, "R2 dbl odd parity");
    send(8'h5A, 0, 0, 0, 1, 8, 3, 5, 0, 1, 8'h5A, "R2 R3 dbl one flip");
    send(8'h00, 0, 0, 0, 1, 8, 4, 4, 6, 1, 8'h08, "R2 R3 dbl two flips");
    idle(2);
    // R10 start at stop sample 8 accepted
    send(8'h99, 0, 0, 0, 1, 7, -1, 0, 0, 1, 8'h99, "R10 first");
    send(8'h66, 0, 0, 0, 1, 8, -1, 0, 0, 1, 8'h66, "R10 start at sample 8");
    idle(4);
    // R10 start at stop sample 7 ignored
    send(8'h24, 0, 0, 0, 1, 6, -1, 0, 0, 1, 8'h24, "R10 before early");
    u0 = unexp;
    send(8'h00, 0, 0, 0, 1, 8, -1, 0, 0, 0, 8'h00, "R10 ignored");
    idle(20);
    check(unexp == u0, "R10 sample 7 ignored", unexp - u0, 0);
    send(8'hE7, 0, 0, 0, 1, 8, -1, 0, 0, 1, 8'hE7, "R10 recovery");
    idle(10);

    check(q.size() == 0, "R8 all frames delivered", q.size(), 0);
    finish_run();
  end
endmodule